// File: doc/BRIEF.md
# Video Sync Activity Monitor and Source Selector

This block sits behind the sync slicers of a dual-input video capture front end. It watches six raw sync lines: a horizontal and a vertical sync for each of two input channels, plus a sliced sync-on-green line for each channel. For every line it reports whether pulses are present and whether the pulses are high-going or low-going.

From the status it picks one horizontal channel and one vertical channel. The picked lines are turned into active-high pulses for the timing logic further down the pipeline. Software can force the horizontal channel. It can also force the vertical polarity used for normalisation in place of the detected one.

All raw lines are resynchronised to the reference clock. Activity is judged over a measurement window whose length is set by a port, in reference clocks. Status bits only change when a window closes.

Top module: `sync_select`

## Requirements
- R1: Each of the six sync lines (hs_raw[1:0], vs_raw[1:0], sog_raw[1:0]) has its own activity bit. The bit is set at the end of a window (win_len+1 reference clocks) in which at least two edges of that line were seen.
- R2: A line held steadily high or steadily low reads as inactive (activity bit 0) from the close of the first full window in which it stayed steady.
- R3: Each line has a polarity bit. 1 means the pulses are high (the high level is the shorter one). 0 means the pulses are low. The bit is 0 after reset and keeps its value while the line is inactive.
- R4: When hs_src_ovr is 1, hs_chan takes the value of hs_src_pick one clock later, whatever the activity is.
- R5: When hs_src_ovr is 0, hs_chan becomes 0 when horizontal channel 0 is active, and 1 when only channel 1 is active. vs_chan follows the same rule from the vertical activity bits and has no override.
- R6: When no channel is active, in automatic mode, the channel selection keeps its previous value. Both selections are 0 after reset.
- R7: When vs_pol_ovr is 1, vs_pol_val (0 = active low, 1 = active high) replaces the detected polarity of the selected vertical line in normalisation.
- R8: hs_norm and vs_norm are the selected synchronised lines inverted when the effective polarity is 0. They are therefore high exactly for the pulse time of each period.
- R9: Activity and polarity bits change only at window boundaries, which are spaced win_len+1 clocks apart from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_raw | input | 2 | Raw horizontal sync, one per channel |
| vs_raw | input | 2 | Raw vertical sync, one per channel |
| sog_raw | input | 2 | Sliced sync-on-green, one per channel |
| win_len | input | CW | Measurement window length minus one, in clocks |
| hs_src_ovr | input | 1 | 1 = horizontal channel forced by hs_src_pick |
| hs_src_pick | input | 1 | Forced horizontal channel |
| vs_pol_ovr | input | 1 | 1 = vertical polarity taken from vs_pol_val |
| vs_pol_val | input | 1 | Forced vertical polarity, 1 = active high |
| hs_active | output | 2 | Horizontal activity per channel |
| hs_polarity | output | 2 | Horizontal polarity per channel |
| vs_active | output | 2 | Vertical activity per channel |
| vs_polarity | output | 2 | Vertical polarity per channel |
| sog_active | output | 2 | Sync-on-green activity per channel |
| sog_polarity | output | 2 | Sync-on-green polarity per channel |
| hs_chan | output | 1 | Selected horizontal channel |
| vs_chan | output | 1 | Selected vertical channel |
| hs_norm | output | 1 | Selected horizontal sync, active high |
| vs_norm | output | 1 | Selected vertical sync, active high |

## Verification
The bench drives mixed polarities at the same time: low pulses on one channel and high pulses on the other. A design that judged polarity from the idle level, or swapped the comparison, would then report the bits backwards and leave the normalised output high for the gap instead of the pulse. Lines held high and held low both have to read inactive, which catches a detector that counts the single edge after reset as activity. Further scenarios remove channel 0 and then channel 1 to show the fall-back and the hold of the last selection. The horizontal override must act in one clock even against an active channel, and the vertical polarity override is flipped both ways. A side monitor checks that every status change falls on the same phase of the window, so status updated mid-window is caught.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;
    typedef struct packed {
        logic act;
        logic pol;
    } sync_stat_t;
endpackage

// File: rtl/sync_monitor.sv
module sync_monitor
    import sync_sel_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic [CW-1:0] win_len,
    output logic          lvl,
    output sync_stat_t    stat
);
    localparam logic [CW-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          prev;
        logic [CW-1:0] cnt;
        logic [CW-1:0] run;
        logic [CW-1:0] hi_len;
        logic [CW-1:0] lo_len;
        logic          hi_ok;
        logic          lo_ok;
        logic [1:0]    edges;
        logic          act;
        logic          pol;
    } mon_t;

    mon_t q, d;
    logic edge_seen;
    logic win_end;
    logic [1:0] edges_now;

    always_comb begin
        d = q;
        d.s1   = raw;
        d.s2   = q.s1;
        d.prev = q.s2;
        edge_seen = (q.s2 != q.prev);
        win_end   = (q.cnt == win_len);
        d.cnt     = win_end ? '0 : q.cnt + 1'b1;

        if (edge_seen) begin
            d.run = {{(CW-1){1'b0}}, 1'b1};
            if (q.prev) begin
                d.hi_len = q.run;
                d.hi_ok  = 1'b1;
            end else begin
                d.lo_len = q.run;
                d.lo_ok  = 1'b1;
            end
        end else if (q.run != RUN_MAX) begin
            d.run = q.run + 1'b1;
        end

        edges_now = (edge_seen && q.edges != 2'd2) ? q.edges + 2'd1 : q.edges;
        d.edges   = win_end ? 2'd0 : edges_now;

        if (win_end) begin
            d.act = (edges_now == 2'd2);
            if (edges_now == 2'd2 && q.hi_ok && q.lo_ok)
                d.pol = (q.hi_len < q.lo_len);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl      = q.s2;
    assign stat.act = q.act;
    assign stat.pol = q.pol;

    AST_QUIET_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        win_end && edges_now != 2'd2 |=> !stat.act); // R2
    AST_STATUS_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(stat.act) && $stable(stat.pol)); // R9
endmodule

// File: rtl/chan_pick.sv
module chan_pick (
    input  logic [1:0] act,
    input  logic       ovr,
    input  logic       pick,
    input  logic       cur,
    output logic       nxt
);
    always_comb begin
        if (ovr)          nxt = pick;
        else if (act[0])  nxt = 1'b0;
        else if (act[1])  nxt = 1'b1;
        else              nxt = cur;
    end
endmodule

// File: rtl/sync_select.sv
module sync_select
    import sync_sel_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    hs_raw,
    input  logic [1:0]    vs_raw,
    input  logic [1:0]    sog_raw,
    input  logic [CW-1:0] win_len,
    input  logic          hs_src_ovr,
    input  logic          hs_src_pick,
    input  logic          vs_pol_ovr,
    input  logic          vs_pol_val,
    output logic [1:0]    hs_active,
    output logic [1:0]    hs_polarity,
    output logic [1:0]    vs_active,
    output logic [1:0]    vs_polarity,
    output logic [1:0]    sog_active,
    output logic [1:0]    sog_polarity,
    output logic          hs_chan,
    output logic          vs_chan,
    output logic          hs_norm,
    output logic          vs_norm
);
    localparam int NCH = 2;

    typedef struct packed {
        logic hs_chan;
        logic vs_chan;
        logic hs_norm;
        logic vs_norm;
    } sel_t;

    sync_stat_t hs_st  [NCH];
    sync_stat_t vs_st  [NCH];
    sync_stat_t sog_st [NCH];
    logic [NCH-1:0] hs_lvl;
    logic [NCH-1:0] vs_lvl;
    logic [NCH-1:0] sog_lvl_unused;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        sync_monitor #(.CW(CW)) u_hs (
            .clk(clk), .rst_n(rst_n), .raw(hs_raw[ch]), .win_len(win_len),
            .lvl(hs_lvl[ch]), .stat(hs_st[ch]));
        sync_monitor #(.CW(CW)) u_vs (
            .clk(clk), .rst_n(rst_n), .raw(vs_raw[ch]), .win_len(win_len),
            .lvl(vs_lvl[ch]), .stat(vs_st[ch]));
        sync_monitor #(.CW(CW)) u_sog (
            .clk(clk), .rst_n(rst_n), .raw(sog_raw[ch]), .win_len(win_len),
            .lvl(sog_lvl_unused[ch]), .stat(sog_st[ch]));

        assign hs_active[ch]    = hs_st[ch].act;
        assign hs_polarity[ch]  = hs_st[ch].pol;
        assign vs_active[ch]    = vs_st[ch].act;
        assign vs_polarity[ch]  = vs_st[ch].pol;
        assign sog_active[ch]   = sog_st[ch].act;
        assign sog_polarity[ch] = sog_st[ch].pol;
    end

    sel_t q, d;
    logic hs_nxt, vs_nxt;
    logic hs_eff_pol, vs_eff_pol;

    chan_pick u_hs_pick (
        .act(hs_active), .ovr(hs_src_ovr), .pick(hs_src_pick),
        .cur(q.hs_chan), .nxt(hs_nxt));
    chan_pick u_vs_pick (
        .act(vs_active), .ovr(1'b0), .pick(1'b0),
        .cur(q.vs_chan), .nxt(vs_nxt));

    always_comb begin
        d = q;
        hs_eff_pol = hs_polarity[q.hs_chan];
        vs_eff_pol = vs_pol_ovr ? vs_pol_val : vs_polarity[q.vs_chan];
        d.hs_chan  = hs_nxt;
        d.vs_chan  = vs_nxt;
        d.hs_norm  = hs_lvl[q.hs_chan] ^ ~hs_eff_pol;
        d.vs_norm  = vs_lvl[q.vs_chan] ^ ~vs_eff_pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hs_chan = q.hs_chan;
    assign vs_chan = q.vs_chan;
    assign hs_norm = q.hs_norm;
    assign vs_norm = q.vs_norm;

    AST_HS_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_src_ovr |=> hs_chan == $past(hs_src_pick)); // R4
    AST_AUTO_PREFER0: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_src_ovr && hs_active[0] |=> !hs_chan); // R5
    AST_AUTO_ONLY1: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_src_ovr && hs_active == 2'b10 |=> hs_chan); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_src_ovr && hs_active == 2'b00 |=> $stable(hs_chan)); // R6
    AST_VS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        vs_active == 2'b00 |=> $stable(vs_chan)); // R6
endmodule

// File: tb/sync_select_test.sv
module sync_select_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 12;
    localparam int WIN = 199;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] hs_raw, vs_raw, sog_raw;
    logic hs_src_ovr = 1'b0, hs_src_pick = 1'b0;
    logic vs_pol_ovr = 1'b0, vs_pol_val = 1'b0;
    logic [1:0] hs_active, hs_polarity, vs_active, vs_polarity, sog_active, sog_polarity;
    logic hs_chan, vs_chan, hs_norm, vs_norm;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_select #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .vs_raw(vs_raw), .sog_raw(sog_raw),
        .win_len(CW'(WIN)), .hs_src_ovr(hs_src_ovr), .hs_src_pick(hs_src_pick),
        .vs_pol_ovr(vs_pol_ovr), .vs_pol_val(vs_pol_val),
        .hs_active(hs_active), .hs_polarity(hs_polarity), .vs_active(vs_active),
        .vs_polarity(vs_polarity), .sog_active(sog_active), .sog_polarity(sog_polarity),
        .hs_chan(hs_chan), .vs_chan(vs_chan), .hs_norm(hs_norm), .vs_norm(vs_norm));

    // pattern generators: 0,1 = hs ; 2,3 = vs ; 4,5 = sog
    logic g_en [6];
    int   g_per[6];
    int   g_wid[6];
    logic g_hi [6];
    logic g_hold[6];
    int   g_ph [6];
    logic lines[6];

    initial begin
        for (int i = 0; i < 6; i++) begin
            g_en[i] = 1'b0; g_per[i] = 10; g_wid[i] = 1;
            g_hi[i] = 1'b0; g_hold[i] = 1'b0; g_ph[i] = 0; lines[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        for (int i = 0; i < 6; i++) begin
            if (g_en[i]) begin
                lines[i] <= (g_ph[i] < g_wid[i]) ? g_hi[i] : ~g_hi[i];
                g_ph[i]  <= (g_ph[i] + 1 >= g_per[i]) ? 0 : g_ph[i] + 1;
            end else begin
                lines[i] <= g_hold[i];
                g_ph[i]  <= 0;
            end
        end
    end

    assign hs_raw  = {lines[1], lines[0]};
    assign vs_raw  = {lines[3], lines[2]};
    assign sog_raw = {lines[5], lines[4]};

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic pulses(input int i, input int per, input int wid, input logic hi);
        g_per[i] = per; g_wid[i] = wid; g_hi[i] = hi; g_en[i] = 1'b1;
    endtask

    task automatic hold(input int i, input logic v);
        g_en[i] = 1'b0; g_hold[i] = v;
    endtask

    task automatic settle();
        repeat (3 * (WIN + 1)) @(negedge clk);
    endtask

    task automatic count_high(input bit vert, input int n, output int cnt);
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cnt += vert ? int'(vs_norm) : int'(hs_norm);
        end
    endtask

    // R9: every status change must fall on the same window phase
    logic [11:0] last_stat;
    int cyc = 0;
    int ref_phase = -1;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if ({hs_active, hs_polarity, vs_active, vs_polarity, sog_active, sog_polarity} != last_stat) begin
                if (ref_phase < 0) ref_phase = cyc % (WIN + 1);
                else chk("R9", "status change phase", cyc % (WIN + 1), ref_phase);
            end
        end
        last_stat <= {hs_active, hs_polarity, vs_active, vs_polarity, sog_active, sog_polarity};
    end

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "hs_active in reset", int'(hs_active), 0);
        chk("R3", "polarity bits in reset", int'({hs_polarity, vs_polarity, sog_polarity}), 0);
        chk("R6", "channel selections in reset", int'({hs_chan, vs_chan}), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        hold(0, 1'b1); hold(1, 1'b0); hold(2, 1'b1); hold(3, 1'b0); hold(4, 1'b1); hold(5, 1'b0);
        settle();
        chk("R2", "held lines hs_active", int'(hs_active), 0);
        chk("R2", "held lines vs/sog active", int'({vs_active, sog_active}), 0);
    endtask

    task automatic t_detect();
        pulses(0, 50, 8, 1'b0);
        pulses(1, 40, 6, 1'b1);
        pulses(2, 100, 10, 1'b1);
        hold(3, 1'b1);
        pulses(4, 60, 5, 1'b0);
        pulses(5, 30, 4, 1'b1);
        settle();
        chk("R1", "hs_active both", int'(hs_active), 3);
        chk("R3", "hs_polarity low/high", int'(hs_polarity), 2);
        chk("R1", "vs_active ch0 only", int'(vs_active), 1);
        chk("R3", "vs_polarity ch0 high", int'(vs_polarity[0]), 1);
        chk("R1", "sog_active both", int'(sog_active), 3);
        chk("R3", "sog_polarity low/high", int'(sog_polarity), 2);
        chk("R5", "hs_chan prefers 0", int'(hs_chan), 0);
        chk("R5", "vs_chan ch0", int'(vs_chan), 0);
    endtask

    task automatic t_norm();
        int c;
        count_high(1'b0, 50, c);
        chk("R8", "hs_norm high cycles per period (low pulses)", c, 8);
        count_high(1'b1, 100, c);
        chk("R8", "vs_norm high cycles per period", c, 10);
    endtask

    task automatic t_vs_override();
        int c;
        vs_pol_ovr = 1'b1; vs_pol_val = 1'b0;
        repeat (4) @(negedge clk);
        count_high(1'b1, 100, c);
        chk("R7", "vs_norm with forced active-low", c, 90);
        vs_pol_val = 1'b1;
        repeat (4) @(negedge clk);
        count_high(1'b1, 100, c);
        chk("R7", "vs_norm with forced active-high", c, 10);
        vs_pol_ovr = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_auto_switch();
        int c;
        hold(0, 1'b1);
        settle();
        chk("R2", "hs0 held goes inactive", int'(hs_active), 2);
        chk("R3", "hs0 polarity kept while inactive", int'(hs_polarity[0]), 0);
        chk("R5", "hs_chan falls to 1", int'(hs_chan), 1);
        count_high(1'b0, 40, c);
        chk("R8", "hs_norm on ch1 high pulses", c, 6);
    endtask

    task automatic t_hold();
        hold(1, 1'b0);
        settle();
        chk("R2", "both hs inactive", int'(hs_active), 0);
        chk("R6", "hs_chan held at 1", int'(hs_chan), 1);
    endtask

    task automatic t_override();
        hs_src_ovr = 1'b1; hs_src_pick = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R4", "forced hs_chan 0", int'(hs_chan), 0);
        pulses(1, 40, 6, 1'b1);
        settle();
        chk("R4", "forced 0 despite only ch1 active", int'(hs_chan), 0);
        hs_src_pick = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R4", "forced hs_chan 1", int'(hs_chan), 1);
        pulses(0, 50, 8, 1'b0);
        settle();
        chk("R4", "forced 1 despite ch0 active", int'(hs_chan), 1);
        hs_src_ovr = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R5", "auto returns to ch0", int'(hs_chan), 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_detect();
        t_norm();
        t_vs_override();
        t_auto_switch();
        t_hold();
        t_override();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule